// File: doc/BRIEF.md
# Request-Acknowledge Latency Checker

This block observes a one-bit request line and a one-bit acknowledge line that share a clock and judges whether every request receives its acknowledge inside a fixed latency window. A request is counted when the request line goes from low to high. Each new request receives a sequence number taken from an issue counter. Several requests may be in flight at once, and acknowledges are paired with them strictly in the order they were issued.

Each pending request's issue time is held in a small queue. The oldest entry is compared with the present cycle. The request is closed on an acknowledge that arrives inside the window, or on expiry. On every close a service counter moves forward, so the service counter is always equal to the sequence number of the oldest pending request. A late or early close pulses a latency error output and reports that request's sequence number. An acknowledge that arrives while nothing is pending pulses a separate spurious error. All outputs are registered, so each verdict appears at the clock edge that ends the cycle in which it was reached.

Top module: `req_ack_latency_checker`

## Requirements
- R1: A request is recognised only in a cycle where `req_i` is high and was low in the cycle before. A line held high for several cycles counts as one request.
- R2: Each recognised request takes the current value of `issued_o` as its sequence number, and `issued_o` rises by one at the clock edge that ends that cycle.
- R3: When the oldest pending request was recognised k cycles earlier, an acknowledge with MIN_LAT ≤ k ≤ MAX_LAT (defaults 1 and 10) closes it without error and raises `served_o` by one.
- R4: When the oldest pending request reaches age MAX_LAT and `ack_i` is low in that cycle, `late_err_o` is high for exactly one cycle after that cycle's edge. `late_tag_o` then shows the request's sequence number and keeps it until the next latency error, and `served_o` rises by one.
- R5: An acknowledge in the same cycle as a request that arrives with nothing pending is a latency violation. `late_err_o` pulses with that request's sequence number, both counters rise by one, and no entry is left pending.
- R6: Acknowledges are credited to the oldest pending request first. A later request cannot be closed while an older one is pending, so `issued_o - served_o` never exceeds DEPTH.
- R7: An acknowledge with nothing pending and no request in the same cycle pulses `spur_err_o` for one cycle and leaves both counters unchanged. This includes an acknowledge that arrives after its request has already expired.
- R8: An acknowledge in the same cycle as a new request, while an older request is pending, closes the older request. The new request is queued and judged later by its own acknowledge.
- R9: A synchronous active-high `rst` clears both counters, the error outputs, the reported sequence number and every pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request line being observed |
| ack_i | input | 1 | Acknowledge line being observed |
| late_err_o | output | 1 | One-cycle pulse when a request closes outside the latency window |
| late_tag_o | output | CNT_W | Sequence number of the most recent failing request |
| spur_err_o | output | 1 | One-cycle pulse for an acknowledge with nothing pending |
| issued_o | output | CNT_W | Number of requests recognised since reset |
| served_o | output | CNT_W | Number of requests closed since reset, passed or failed |

## Verification
Two functions of this block can fall in the same cycle: closing the oldest pending request and queuing a new one. The bench makes them coincide in two ways. First, an acknowledge for an older request is driven on the exact cycle where the request line rises again. Second, a second request is kept pending while the first one expires, so the second request's own acknowledge then lands inside its window. The result is judged at the ports. The error pulse must carry the older sequence number, the counters must move by one each, and the newer request must then pass on its own acknowledge.

// File: rtl/rk_pkg.sv
package rk_pkg;

    // Outcome for the oldest pending request (or a stray acknowledge) in one cycle
    typedef enum logic [1:0] {
        V_NONE = 2'd0,
        V_PASS = 2'd1,
        V_LATE = 2'd2,
        V_SPUR = 2'd3
    } verdict_e;

endpackage

// File: rtl/rk_rise_detect.sv
module rk_rise_detect (
    input  logic clk,
    input  logic lvl_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    // The previous level follows the line through reset as well, so a line
    // that stays high across reset is not taken as a fresh request.
    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i && !prev_q;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

endmodule

// File: rtl/rk_stamp_fifo.sv
module rk_stamp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] push_stamp_i,
    input  logic         pop_i,
    output logic [W-1:0] head_stamp_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        empty_o      = (f_q.cnt == '0);
        full_o       = (f_q.cnt == CW'(DEPTH));
        head_stamp_o = f_q.mem[f_q.rd];
        do_push      = push_i && !full_o;
        do_pop       = pop_i && !empty_o;

        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wr] = push_stamp_i;
            f_d.wr          = step(f_q.wr);
        end
        if (do_pop) begin
            f_d.rd = step(f_q.rd);
        end
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);

        if (rst) begin
            f_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

endmodule

// File: rtl/req_ack_latency_checker.sv
module req_ack_latency_checker #(
    parameter int MIN_LAT = 1,
    parameter int MAX_LAT = 10,
    parameter int DEPTH   = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             ack_i,
    output logic             late_err_o,
    output logic [CNT_W-1:0] late_tag_o,
    output logic             spur_err_o,
    output logic [CNT_W-1:0] issued_o,
    output logic [CNT_W-1:0] served_o
);

    import rk_pkg::*;

    // The cycle stamp only has to measure ages up to MAX_LAT without wrapping
    localparam int AGE_W = $clog2(MAX_LAT + 2) + 1;

    typedef struct packed {
        logic [AGE_W-1:0] now;
        logic [CNT_W-1:0] issued;
        logic [CNT_W-1:0] served;
        logic [CNT_W-1:0] tag;
        logic             late;
        logic             spur;
    } state_t;

    state_t           s_d, s_q;
    logic             rise;
    logic             fifo_empty, fifo_full;
    logic             push_w, pop_w, closed;
    logic [AGE_W-1:0] head_stamp, head_age;
    verdict_e         verdict;

    rk_rise_detect u_edge (
        .clk    (clk),
        .lvl_i  (req_i),
        .rise_o (rise)
    );

    rk_stamp_fifo #(
        .DEPTH (DEPTH),
        .W     (AGE_W)
    ) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .push_i       (push_w),
        .push_stamp_i (s_q.now),
        .pop_i        (pop_w),
        .head_stamp_o (head_stamp),
        .empty_o      (fifo_empty),
        .full_o       (fifo_full)
    );

    always_comb begin
        head_age = s_q.now - head_stamp;

        // Judge the oldest pending request; with none pending, judge the acknowledge
        verdict = V_NONE;
        if (!fifo_empty) begin
            if (ack_i) begin
                verdict = (head_age < AGE_W'(MIN_LAT)) ? V_LATE : V_PASS;
            end else if (head_age >= AGE_W'(MAX_LAT)) begin
                verdict = V_LATE;
            end
        end else if (ack_i) begin
            if (rise) begin
                verdict = (MIN_LAT > 0) ? V_LATE : V_PASS;
            end else begin
                verdict = V_SPUR;
            end
        end

        closed = (verdict == V_PASS) || (verdict == V_LATE);
        pop_w  = closed && !fifo_empty;
        // A request met by its acknowledge in the same cycle is closed at once
        push_w = rise && !(fifo_empty && ack_i);

        s_d        = s_q;
        s_d.now    = s_q.now + AGE_W'(1);
        s_d.issued = s_q.issued + CNT_W'(rise);
        s_d.served = s_q.served + CNT_W'(closed);
        s_d.late   = (verdict == V_LATE);
        s_d.spur   = (verdict == V_SPUR);
        if (verdict == V_LATE) begin
            s_d.tag = s_q.served;
        end

        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign late_err_o = s_q.late;
    assign late_tag_o = s_q.tag;
    assign spur_err_o = s_q.spur;
    assign issued_o   = s_q.issued;
    assign served_o   = s_q.served;

endmodule

// File: rtl/rk_checker.sv
module rk_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_i,
    input logic             ack_i,
    input logic             late_err_o,
    input logic [CNT_W-1:0] late_tag_o,
    input logic             spur_err_o,
    input logic [CNT_W-1:0] issued_o,
    input logic [CNT_W-1:0] served_o,
    input logic             push_i,
    input logic             full_i
);

    // R2
    issue_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_i) |=> issued_o == $past(issued_o) + CNT_W'(1));

    // R1
    held_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && $past(req_i)) |=> issued_o == $past(issued_o));

    // R4
    late_tag_chk: assert property (@(posedge clk) disable iff (rst)
        late_err_o |-> (late_tag_o == $past(served_o)) && (served_o == $past(served_o) + CNT_W'(1)));

    // R7
    spur_count_chk: assert property (@(posedge clk) disable iff (rst)
        spur_err_o |-> (served_o == $past(served_o)) && (issued_o == $past(issued_o)) && !late_err_o);

    // R6
    order_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (issued_o - served_o) <= CNT_W'(DEPTH));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push_i && full_i));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (issued_o == '0) && (served_o == '0) && !late_err_o && !spur_err_o && (late_tag_o == '0));

endmodule

bind req_ack_latency_checker rk_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_rk_checker (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .ack_i      (ack_i),
    .late_err_o (late_err_o),
    .late_tag_o (late_tag_o),
    .spur_err_o (spur_err_o),
    .issued_o   (issued_o),
    .served_o   (served_o),
    .push_i     (push_w),
    .full_i     (fifo_full)
);

// File: tb/req_ack_latency_checker_test.sv
`timescale 1ns/1ps
module req_ack_latency_checker_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             ack = 1'b0;
    logic             late_err, spur_err;
    logic [CNT_W-1:0] late_tag, issued, served;

    int checks = 0;
    int errors = 0;
    int exp_iss = 0;
    int exp_srv = 0;

    always #10 clk = ~clk;

    req_ack_latency_checker #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .ack_i      (ack),
        .late_err_o (late_err),
        .late_tag_o (late_tag),
        .spur_err_o (spur_err),
        .issued_o   (issued),
        .served_o   (served)
    );

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    // Drive one cycle; afterwards the outputs show that cycle's verdict
    task automatic cyc(input logic r, input logic a);
        req = r;
        ack = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_quiet(input int n, input string r);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b0);
            chk(r, int'(late_err), 0);
        end
    endtask

    task automatic counts(input string r);
        chk({r, " issued"}, int'(issued), exp_iss);
        chk({r, " served"}, int'(served), exp_srv);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        rst = 1'b0;
        exp_iss = 0;
        exp_srv = 0;
        counts("R9 reset");
        chk("R9 reset late", int'(late_err), 0);
        chk("R9 reset spur", int'(spur_err), 0);
        chk("R9 reset tag", int'(late_tag), 0);
    endtask

    task automatic t_short_pass;
        cyc(1'b1, 1'b0);
        exp_iss++;
        counts("R2 new request");
        cyc(1'b0, 1'b1);
        exp_srv++;
        chk("R3 age 1 late", int'(late_err), 0);
        chk("R3 age 1 spur", int'(spur_err), 0);
        counts("R3 age 1");
    endtask

    task automatic t_held_high;
        cyc(1'b1, 1'b0);
        exp_iss++;
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        counts("R1 held high");
        cyc(1'b0, 1'b1);
        exp_srv++;
        chk("R1 held ack late", int'(late_err), 0);
        counts("R1 held ack");
    endtask

    task automatic t_max_edge;
        cyc(1'b1, 1'b0);
        exp_iss++;
        idle_quiet(9, "R3 waiting");
        cyc(1'b0, 1'b1);
        exp_srv++;
        chk("R3 age 10 late", int'(late_err), 0);
        counts("R3 age 10");
    endtask

    task automatic t_timeout;
        int tag = exp_srv;
        cyc(1'b1, 1'b0);
        exp_iss++;
        idle_quiet(9, "R4 before expiry");
        cyc(1'b0, 1'b0);
        exp_srv++;
        chk("R4 expiry pulse", int'(late_err), 1);
        chk("R4 expiry tag", int'(late_tag), tag);
        counts("R4 expiry");
        cyc(1'b0, 1'b1);
        chk("R4 pulse one cycle", int'(late_err), 0);
        chk("R7 ack after expiry", int'(spur_err), 1);
        counts("R7 ack after expiry");
        chk("R4 tag held", int'(late_tag), tag);
    endtask

    task automatic t_zero;
        int tag = exp_iss;
        cyc(1'b1, 1'b1);
        exp_iss++;
        exp_srv++;
        chk("R5 zero latency pulse", int'(late_err), 1);
        chk("R5 zero latency tag", int'(late_tag), tag);
        chk("R5 zero latency spur", int'(spur_err), 0);
        counts("R5 zero latency");
        cyc(1'b0, 1'b0);
        chk("R5 pulse ends", int'(late_err), 0);
        cyc(1'b0, 1'b1);
        chk("R5 nothing left pending", int'(spur_err), 1);
        counts("R5 after");
    endtask

    task automatic t_spur;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        chk("R7 stray ack", int'(spur_err), 1);
        chk("R7 stray late", int'(late_err), 0);
        counts("R7 stray");
        cyc(1'b0, 1'b0);
        chk("R7 pulse ends", int'(spur_err), 0);
    endtask

    task automatic t_order;
        int tag_a = exp_srv;
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        exp_iss += 2;
        counts("R6 two pending");
        idle_quiet(7, "R6 first waiting");
        cyc(1'b0, 1'b0);
        exp_srv++;
        chk("R6 first expires", int'(late_err), 1);
        chk("R6 older tag reported", int'(late_tag), tag_a);
        cyc(1'b0, 1'b1);
        exp_srv++;
        chk("R6 second passes", int'(late_err), 0);
        chk("R6 second no spur", int'(spur_err), 0);
        counts("R6 both closed");
    endtask

    task automatic t_same_cycle;
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b1);
        exp_iss += 2;
        exp_srv++;
        chk("R8 ack to older", int'(late_err), 0);
        chk("R8 no spur", int'(spur_err), 0);
        counts("R8 ack with new request");
        cyc(1'b0, 1'b1);
        exp_srv++;
        chk("R8 newer passes", int'(late_err), 0);
        chk("R8 newer no spur", int'(spur_err), 0);
        counts("R8 newer closed");
    endtask

    task automatic t_reset_mid;
        cyc(1'b1, 1'b0);
        rst = 1'b1;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        rst = 1'b0;
        exp_iss = 0;
        exp_srv = 0;
        counts("R9 mid reset");
        chk("R9 mid reset tag", int'(late_tag), 0);
        idle_quiet(12, "R9 pending dropped");
        cyc(1'b0, 1'b1);
        chk("R9 queue empty", int'(spur_err), 1);
        counts("R9 after");
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_short_pass();
        t_held_high();
        t_max_edge();
        t_timeout();
        t_zero();
        t_spur();
        t_order();
        t_same_cycle();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule